// File: doc/BRIEF.md
# Video Sync Word Conditioner

This block sits at the front of a serial digital video transmit path. On every rising edge of the word clock it registers a parallel video word together with two control inputs. The first is an active-low enable for sync-code rounding. The second selects video mode. The registered word is then conditioned and handed on to the scrambler that follows.

When rounding is enabled, a word whose upper bits are all zeros or all ones is treated as a timing-reference (sync) character. Its low bits are forced to the matching exact value. A source that carries only the upper bits of each word therefore still produces exact sync codes.

A separate active-low flag reports whether the most recently registered word is a sync character while video mode is selected. The flag stays low for as long as such characters keep arriving. It returns high on the first ordinary word, or as soon as video mode is latched off.

Top module: `vid_sync_cond`

## Requirements
- R1: The word, the rounding enable and the mode input are all sampled on the same rising clock edge. Both outputs reflect the values sampled at the most recent edge, with no further cycle of delay.
- R2: With rounding enabled (`snap_n_i` = 0), a registered word whose upper `WORD_W-SNAP_W` bits are all zeros leaves the block with its low `SNAP_W` bits forced to 0. With the default widths, 0x000–0x003 all become 0x000.
- R3: With rounding enabled, a registered word whose upper bits are all ones leaves the block with its low `SNAP_W` bits forced to 1. With the default widths, 0x3FC–0x3FF all become 0x3FF.
- R4: With rounding disabled (`snap_n_i` = 1), every word, sync-like or not, leaves the block unchanged.
- R5: With rounding enabled, a word whose upper bits are neither all zeros nor all ones leaves the block unchanged.
- R6: `sync_n_o` is 0 after an edge that registers a word with upper bits all zeros or all ones while `vid_mode_i` = 1. The state of the rounding enable has no effect on this.
- R7: `sync_n_o` is 1 after an edge that registers a word whose upper bits are mixed, or that registers `vid_mode_i` = 0.
- R8: A synchronous active-high reset sets the output word to 0 and `sync_n_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| word_i | input | WORD_W | Parallel video word |
| snap_n_i | input | 1 | Sync-code rounding enable, active low |
| vid_mode_i | input | 1 | Video mode select, 1 = video mode |
| word_o | output | WORD_W | Conditioned word for the scrambler |
| sync_n_o | output | 1 | Sync character detected, active low |

## Verification
The bench builds the block with its defaults: a 10-bit word with 2 rounded low bits, which leaves an 8-bit sync field. At these widths the whole input space is only 1024 values. A full sweep of every word, with rounding both on and off, therefore reaches every near-sync code at both ends as well as each of their neighbours just outside the range. Mode is toggled while sync runs are in progress, so the flag is seen both while it holds and while it releases.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   typedef enum logic [1:0] {
      CLS_PLAIN = 2'd0,
      CLS_LOW   = 2'd1,
      CLS_HIGH  = 2'd2
   } sync_cls_e;
endpackage

// File: rtl/vsc_in_reg.sv
module vsc_in_reg #(
   parameter int WORD_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              snap_n_i,
   output logic [WORD_W-1:0] word_q,
   output logic              snap_n_q
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         word_q   <= '0;
         snap_n_q <= 1'b1;
      end else begin
         word_q   <= word_i;
         snap_n_q <= snap_n_i;
      end
   end
endmodule

// File: rtl/vsc_classify.sv
module vsc_classify
   import vsc_pkg::*;
#(
   parameter int UPPER_W = 8
) (
   input  logic [UPPER_W-1:0] upper_i,
   output sync_cls_e          cls_o
);
   always_comb begin
      if (upper_i == '0)
         cls_o = CLS_LOW;
      else if (upper_i == '1)
         cls_o = CLS_HIGH;
      else
         cls_o = CLS_PLAIN;
   end
endmodule

// File: rtl/vsc_snap.sv
module vsc_snap
   import vsc_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int SNAP_W = 2
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              snap_n_i,
   input  sync_cls_e         cls_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int UPPER_W = WORD_W - SNAP_W;

   logic force_lo;
   logic force_hi;

   assign force_lo = !snap_n_i && (cls_i == CLS_LOW);
   assign force_hi = !snap_n_i && (cls_i == CLS_HIGH);

   assign word_o[WORD_W-1:SNAP_W] = word_i[WORD_W-1:SNAP_W];

   for (genvar b = 0; b < SNAP_W; b++) begin : g_low
      assign word_o[b] = force_hi ? 1'b1 : (force_lo ? 1'b0 : word_i[b]);
   end

   if (UPPER_W < 1) begin : g_bad
      $error("vsc_snap: SNAP_W must leave at least one upper bit");
   end
endmodule

// File: rtl/vsc_flag.sv
module vsc_flag
   import vsc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      vid_mode_i,
   input  sync_cls_e cls_i,
   output logic      sync_n_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)
         sync_n_o <= 1'b1;
      else
         sync_n_o <= !(vid_mode_i && (cls_i != CLS_PLAIN));
   end
endmodule

// File: rtl/vid_sync_cond.sv
module vid_sync_cond
   import vsc_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int SNAP_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              snap_n_i,
   input  logic              vid_mode_i,
   output logic [WORD_W-1:0] word_o,
   output logic              sync_n_o
);
   localparam int UPPER_W = WORD_W - SNAP_W;

   if (SNAP_W < 1 || UPPER_W < 2) begin : g_param_chk
      $error("vid_sync_cond: need SNAP_W >= 1 and WORD_W - SNAP_W >= 2");
   end

   logic [WORD_W-1:0] word_q;
   logic              snap_n_q;
   sync_cls_e         cls_reg;
   sync_cls_e         cls_in;

   vsc_in_reg #(.WORD_W(WORD_W)) u_in_reg (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .word_i  (word_i),
      .snap_n_i(snap_n_i),
      .word_q  (word_q),
      .snap_n_q(snap_n_q)
   );

   vsc_classify #(.UPPER_W(UPPER_W)) u_cls_reg (
      .upper_i(word_q[WORD_W-1:SNAP_W]),
      .cls_o  (cls_reg)
   );

   vsc_snap #(.WORD_W(WORD_W), .SNAP_W(SNAP_W)) u_snap (
      .word_i  (word_q),
      .snap_n_i(snap_n_q),
      .cls_i   (cls_reg),
      .word_o  (word_o)
   );

   vsc_classify #(.UPPER_W(UPPER_W)) u_cls_in (
      .upper_i(word_i[WORD_W-1:SNAP_W]),
      .cls_o  (cls_in)
   );

   vsc_flag u_flag (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .vid_mode_i(vid_mode_i),
      .cls_i     (cls_in),
      .sync_n_o  (sync_n_o)
   );

   // Assertions relate input ports at one edge to output ports after it
   logic in_lo, in_hi;
   assign in_lo = (word_i[WORD_W-1:SNAP_W] == '0);
   assign in_hi = (word_i[WORD_W-1:SNAP_W] == '1);

   // R2
   p_snap_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!snap_n_i && in_lo) |=> (word_o == '0));
   // R3
   p_snap_high_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!snap_n_i && in_hi) |=> (word_o == '1));
   // R4
   p_pass_off_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      snap_n_i |=> (word_o == $past(word_i)));
   // R5
   p_pass_plain_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!in_lo && !in_hi) |=> (word_o == $past(word_i)));
   // R6
   p_flag_set_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (vid_mode_i && (in_lo || in_hi)) |=> !sync_n_o);
   // R7
   p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!vid_mode_i || (!in_lo && !in_hi)) |=> sync_n_o);
endmodule

// File: tb/test_vid_sync_cond.sv
`timescale 1ns/1ps
module test_vid_sync_cond;
   localparam int W = 10;
   localparam int S = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] word_in = '0;
   logic         snap_n = 1'b1;
   logic         vmode = 1'b0;
   logic [W-1:0] word_out;
   logic         sync_n;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit armed = 0;

   logic [W-1:0] exp_w;
   logic         exp_f;
   string        tag_w;
   string        tag_f;

   always #2 clk = ~clk;

   vid_sync_cond #(.WORD_W(W), .SNAP_W(S)) i_vid_sync_cond (
      .clk_i(clk), .rst_i(rst), .word_i(word_in), .snap_n_i(snap_n),
      .vid_mode_i(vmode), .word_o(word_out), .sync_n_o(sync_n)
   );

   // Reference model: outputs follow what was sampled at the last edge (R1)
   always @(posedge clk) begin
      int up;
      up = int'(word_in >> S);
      armed = 1;
      if (rst) begin
         exp_w = '0; exp_f = 1'b1; tag_w = "R8"; tag_f = "R8";
      end else begin
         if (snap_n) begin
            exp_w = word_in; tag_w = "R1,R4";
         end else if (up == 0) begin
            exp_w = '0; tag_w = "R1,R2";
         end else if (up == (1 << (W - S)) - 1) begin
            exp_w = '1; tag_w = "R1,R3";
         end else begin
            exp_w = word_in; tag_w = "R1,R5";
         end
         if (vmode && (up == 0 || up == (1 << (W - S)) - 1)) begin
            exp_f = 1'b0; tag_f = "R6";
         end else begin
            exp_f = 1'b1; tag_f = "R7";
         end
      end
   end

   always @(negedge clk) begin
      if (armed && !done) begin
         total++;
         if (word_out !== exp_w) begin
            bad++;
            $display("FAIL %s word_o actual=%h expected=%h", tag_w, word_out, exp_w);
         end
         total++;
         if (sync_n !== exp_f) begin
            bad++;
            $display("FAIL %s sync_n_o actual=%b expected=%b", tag_f, sync_n, exp_f);
         end
      end
   end

   task automatic drive(input logic [W-1:0] w, input logic f, input logic m);
      @(posedge clk);
      #1;
      word_in = w; snap_n = f; vmode = m;
   endtask

   initial begin
      // R8: reset held for a few edges with sync-like data present
      word_in = 10'h3FE; snap_n = 1'b0; vmode = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R2 R3 R4 R5: every word with rounding on and off
      for (int f = 0; f < 2; f++)
         for (int v = 0; v < (1 << W); v++)
            drive(W'(v), f[0], 1'b1);
      // R6 R7: sync run held, then mode dropped mid-run, then restored
      for (int k = 0; k < 6; k++) drive(10'h000 + W'(k % 4), 1'b1, 1'b1);
      drive(10'h3FD, 1'b1, 1'b0);
      drive(10'h3FD, 1'b1, 1'b1);
      drive(10'h200, 1'b0, 1'b1);
      drive(10'h004, 1'b0, 1'b1);
      drive(10'h3FB, 1'b0, 1'b1);
      // Random mix
      for (int k = 0; k < 600; k++) begin
         logic [W-1:0] r;
         r = W'($urandom);
         if (k % 3 == 0) r[W-1:S] = ($urandom % 2) ? '1 : '0;
         drive(r, 1'($urandom), 1'($urandom));
      end
      // R8: reset mid-stream
      @(posedge clk); #1 rst = 1'b1;
      drive(10'h001, 1'b0, 1'b1);
      @(posedge clk); #1 rst = 1'b0;
      drive(10'h155, 1'b0, 1'b0);
      repeat (2) @(posedge clk);
      @(negedge clk); #0.5;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule